// File: doc/BRIEF.md
# Serial Register-to-Register Transfer Unit

This block copies the contents of one shift register into a second one over a serial path, one bit per clock, while leaving the source intact. Two registers of equal width, called source (A) and destination (B), share one clock. During a transfer both move one place toward their least significant end on every edge. The bit that drops out of the low end of A goes back into the top of A and also into the top of B.

A parallel load strobe writes both registers from external inputs. A start pulse then begins a transfer that runs for exactly as many edges as the registers have bits. After the last shift, B holds the value A had when the transfer began, and A is back at that same value. A single-cycle done pulse marks the end of the transfer. The block is used wherever a word must be duplicated over a one-wire link without a spare holding register.

Top module: `serial_xfer_unit`

## Requirements
- R1: While rst_n is low at a rising edge, both registers are cleared to zero, the done output is cleared and any transfer in progress is abandoned.
- R2: When load is high at an edge, A takes a_init and B takes b_init on that edge. Load wins over shifting and over start on the same edge, cancels any running transfer, and no done pulse follows the cancelled transfer.
- R3: On every shifting edge, A rotates right by one: bit 0 moves to bit WIDTH-1 and every other bit moves one place down.
- R4: On the same shifting edge, B shifts right by one and its new bit WIDTH-1 equals the old bit 0 of A.
- R5: A start pulse seen at an edge while idle and without load arms a transfer. Shifting happens on exactly the WIDTH edges that follow that edge, and the sampling edge itself does not shift.
- R6: done is high for exactly one cycle, directly after the edge that performs the WIDTH-th shift, and is low at all other times.
- R7: When done is high, B equals A, and both equal A's value at the start of the transfer. For example, A=1011 and B=0011 step through (1101,1001), (1110,1100), (0111,0110) and (1011,1011).
- R8: A start pulse that arrives while a transfer is running is ignored. It neither restarts nor lengthens the transfer.
- R9: When there is no load, no reset and no running transfer, both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Parallel write strobe for both registers |
| start | input | 1 | Begins a transfer when the unit is idle |
| a_init | input | WIDTH | Parallel value for source register A |
| b_init | input | WIDTH | Parallel value for destination register B |
| a_q | output | WIDTH | Current contents of A |
| b_q | output | WIDTH | Current contents of B |
| done | output | 1 | One-cycle pulse when a transfer completes |

## Verification
The assertions check the relations that hold on every cycle. A shift keeps the number of ones in A unchanged. B's new top bit is A's old low bit. Both registers hold when nothing acts on them. A load lands its inputs. done is never longer than one cycle, and whenever done is high, B matches A. Some behaviours can only be shown by the bench's scenarios, which compare the design against a behavioural model on every clock. These are the exact count of WIDTH shifts after a start, the fixed sequence of register pairs, start being ignored during a transfer, and load cancelling a transfer without a done pulse.

// File: rtl/srx_pkg.sv
// Shared types for the serial register-to-register transfer unit.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package srx_pkg;

    // Sequencer phase: waiting for a start, or shifting.
    typedef enum logic {
        XFER_IDLE = 1'b0,
        XFER_RUN  = 1'b1
    } xfer_phase_t;

endpackage

// File: rtl/srx_src_reg.sv
// Source register A. Rotates right by one place when shift_en is high.
// Writes par_in when wr_en is high; wr_en wins over shift_en.
// Assumes: rst_n is synchronous and active low, and WIDTH >= 2.
module srx_src_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             shift_en,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q,
    output logic             ser_out
);

    // Bit that leaves the low end on a shift.
    assign ser_out = q[0];

    // Holds, loads or rotates the source word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= par_in;
        end else if (shift_en) begin
            q <= {q[0], q[WIDTH-1:1]};
        end
    end

    // R3
    rotate_keeps_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !wr_en) |=> ($countones(q) == $countones($past(q))));

    // R2
    src_load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(par_in)));

endmodule

// File: rtl/srx_dst_reg.sv
// Destination register B. Shifts right by one place when shift_en is high,
// taking ser_in into its top bit. Writes par_in when wr_en is high;
// wr_en wins over shift_en.
// Assumes: rst_n is synchronous and active low, and WIDTH >= 2.
module srx_dst_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             shift_en,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q
);

    // Holds, loads or shifts in the serial bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= par_in;
        end else if (shift_en) begin
            q <= {ser_in, q[WIDTH-1:1]};
        end
    end

    // R2
    dst_load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(par_in)));

endmodule

// File: rtl/srx_seq.sv
// Transfer sequencer. A start pulse while idle arms a run of WIDTH shift
// edges. The registered done output pulses for one cycle after the last
// shift. A load cancels the run, and so does reset.
// Assumes: rst_n is synchronous and active low, and WIDTH >= 2.
module srx_seq
    import srx_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic start,
    output logic shift_en,
    output logic done
);

    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    xfer_phase_t   phase;
    logic [CW-1:0] cnt;

    // A shift happens on every running edge that is not taken by a load.
    assign shift_en = (phase == XFER_RUN) && !load;

    // Advances the phase and the shift counter, and makes the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= XFER_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                phase <= XFER_IDLE;
                cnt   <= '0;
            end else if (phase == XFER_RUN) begin
                if (cnt == LAST) begin
                    phase <= XFER_IDLE;
                    cnt   <= '0;
                    done  <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (start) begin
                phase <= XFER_RUN;
                cnt   <= '0;
            end
        end
    end

    // R6
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    run_counts_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == XFER_RUN && !load && cnt != LAST) |=>
            (phase == XFER_RUN && cnt == $past(cnt) + 1'b1));

    // R2
    load_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (phase == XFER_IDLE && !done));

endmodule

// File: rtl/serial_xfer_unit.sv
// Serial register-to-register transfer unit. Source A rotates into itself
// and copies each outgoing bit into destination B. After WIDTH shifts,
// B equals A and A is unchanged.
// Assumes: rst_n is synchronous and active low, and the inputs are
// synchronous to clk.
module serial_xfer_unit #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             start,
    input  logic [WIDTH-1:0] a_init,
    input  logic [WIDTH-1:0] b_init,
    output logic [WIDTH-1:0] a_q,
    output logic [WIDTH-1:0] b_q,
    output logic             done
);

    logic shift_en;
    logic link_bit;

    // Sequencer: decides which edges shift.
    srx_seq #(.WIDTH(WIDTH)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .start    (start),
        .shift_en (shift_en),
        .done     (done)
    );

    // Source register with rotate feedback.
    srx_src_reg #(.WIDTH(WIDTH)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (load),
        .shift_en (shift_en),
        .par_in   (a_init),
        .q        (a_q),
        .ser_out  (link_bit)
    );

    // Destination register fed by the serial link.
    srx_dst_reg #(.WIDTH(WIDTH)) u_dst (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (load),
        .shift_en (shift_en),
        .ser_in   (link_bit),
        .par_in   (b_init),
        .q        (b_q)
    );

    // R4
    link_bit_enters_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (b_q[WIDTH-1] == $past(a_q[0])));

    // R7
    copy_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (b_q == a_q));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !load) |=> ($stable(a_q) && $stable(b_q)));

endmodule

// File: tb/serial_xfer_unit_tb.sv
// Bench: a behavioural model stepped on each rising edge and compared on
// every falling edge, plus named scenario checks.
module serial_xfer_unit_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] a_init = '0;
    logic [W-1:0] b_init = '0;
    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    logic         done;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    // Model state
    logic [W-1:0] ma = '0;
    logic [W-1:0] mb = '0;
    logic         mdone = 1'b0;
    int           remaining = 0;
    bit           model_on = 1'b0;

    always #10 clk = ~clk;

    serial_xfer_unit #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .start(start),
        .a_init(a_init), .b_init(b_init),
        .a_q(a_q), .b_q(b_q), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Behavioural model of the requirements (R1-R9 semantics)
    always @(posedge clk) begin
        logic lowbit;
        if (!rst_n) begin
            ma = '0; mb = '0; mdone = 1'b0; remaining = 0;
        end else begin
            mdone = 1'b0;
            if (load) begin
                ma = a_init; mb = b_init; remaining = 0;
            end else if (remaining > 0) begin
                lowbit = ma[0];
                ma = (ma >> 1) | (W'(lowbit) << (W - 1));
                mb = (mb >> 1) | (W'(lowbit) << (W - 1));
                remaining--;
                if (remaining == 0) mdone = 1'b1;
            end else if (start) begin
                remaining = W;
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (model_on) begin
            check(a_q == ma, "R3", "model A", {1'b0, a_q}, {1'b0, ma});
            check(b_q == mb, "R4", "model B", {1'b0, b_q}, {1'b0, mb});
            check(done == mdone, "R6", "model done", {{W{1'b0}}, done}, {{W{1'b0}}, mdone});
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_load(input logic [W-1:0] av, input logic [W-1:0] bv);
        load = 1'b1; a_init = av; b_init = bv;
        tick();
        load = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    initial begin
        tick(); tick();
        // R1: reset state
        check(a_q == '0 && b_q == '0, "R1", "regs after reset", {1'b0, a_q | b_q}, '0);
        check(done == 1'b0, "R1", "done after reset", {{W{1'b0}}, done}, '0);
        rst_n = 1'b1;
        model_on = 1'b1;
        tick();

        // R2: load of the example values
        do_load(4'b1011, 4'b0011);
        check(a_q == 4'b1011 && b_q == 4'b0011, "R2", "loaded pair",
              {1'b0, a_q}, {1'b0, 4'b1011});

        // R9: idle hold
        tick(); tick();
        check(a_q == 4'b1011 && b_q == 4'b0011, "R9", "idle hold",
              {1'b0, b_q}, {1'b0, 4'b0011});

        // R5: the start sampling edge does not shift
        pulse_start();
        check(a_q == 4'b1011 && b_q == 4'b0011, "R5", "no shift on start edge",
              {1'b0, a_q}, {1'b0, 4'b1011});
        // R7: fixed sequence of pairs, R3/R4 per step
        tick();
        check(a_q == 4'b1101 && b_q == 4'b1001, "R7", "step 1", {1'b0, b_q}, {1'b0, 4'b1001});
        tick();
        check(a_q == 4'b1110 && b_q == 4'b1100, "R7", "step 2", {1'b0, b_q}, {1'b0, 4'b1100});
        tick();
        check(a_q == 4'b0111 && b_q == 4'b0110, "R7", "step 3", {1'b0, b_q}, {1'b0, 4'b0110});
        tick();
        check(a_q == 4'b1011 && b_q == 4'b1011, "R7", "step 4", {1'b0, b_q}, {1'b0, 4'b1011});
        check(done == 1'b1, "R6", "done after last shift", {{W{1'b0}}, done}, 1);
        tick();
        check(done == 1'b0, "R6", "done one cycle", {{W{1'b0}}, done}, 0);
        check(a_q == 4'b1011 && b_q == 4'b1011, "R5", "stops after W shifts",
              {1'b0, a_q}, {1'b0, 4'b1011});

        // R8: start while running is ignored
        do_load(4'b0110, 4'b1111);
        pulse_start();
        tick();
        start = 1'b1; tick(); start = 1'b0;   // shift 2 edge saw extra start
        tick(); tick();
        check(done == 1'b1 && b_q == 4'b0110, "R8", "done at normal time",
              {done, b_q}, {1'b1, 4'b0110});
        tick();
        check(done == 1'b0 && a_q == 4'b0110, "R8", "no second transfer",
              {done, a_q}, {1'b0, 4'b0110});
        tick();
        check(a_q == 4'b0110, "R8", "still holding", {1'b0, a_q}, {1'b0, 4'b0110});

        // R2: load mid-transfer cancels, wins over shift
        do_load(4'b1000, 4'b0000);
        pulse_start();
        tick();
        load = 1'b1; a_init = 4'b0101; b_init = 4'b1010; start = 1'b1;
        tick();
        load = 1'b0; start = 1'b0;
        check(a_q == 4'b0101 && b_q == 4'b1010, "R2", "load beats shift",
              {1'b0, a_q}, {1'b0, 4'b0101});
        for (int i = 0; i < W + 2; i++) begin
            check(done == 1'b0, "R2", "no done after cancel", {{W{1'b0}}, done}, 0);
            check(a_q == 4'b0101, "R2", "cancelled stays put", {1'b0, a_q}, {1'b0, 4'b0101});
            tick();
        end

        // R1: reset mid-transfer
        pulse_start();
        tick();
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        check(a_q == '0 && b_q == '0 && done == 1'b0, "R1", "reset mid-run",
              {done, a_q | b_q}, '0);
        tick(); tick(); tick(); tick(); tick();
        check(done == 1'b0, "R1", "no done after reset abort", {{W{1'b0}}, done}, 0);

        // Several patterns through the model, back to back
        for (int p = 0; p < 16; p++) begin
            do_load(W'(p * 7 + 3), W'(~p));
            pulse_start();
            for (int k = 0; k < W + 1; k++) tick();
            check(b_q == W'(p * 7 + 3), "R7", "copy pattern", {1'b0, b_q}, {1'b0, W'(p * 7 + 3)});
        end

        tick();
        finish_run();
    end

endmodule